// File: doc/BRIEF.md
# Page-Mode Parallel ROM Reader

This block is a synchronous host-side controller for an asynchronous, page-organised parallel read-only memory. A host hands it a read request made of a start address, a beat count and a width mode (16-bit words or 8-bit bytes) on a valid/ready handshake. The reader then drives the memory's chip-enable, output-enable, width-select line and address bus. For each beat it waits a number of clock cycles and samples the data bus. Each result goes back on a one-cycle valid/data/last stream.

The memory holds 4M 16-bit words or 8M bytes. A page is 8 words or 16 bytes, and all address lines above the three in-page word bits select the page. The first read into a page needs the full random-access latency of 90 ns. A read that changes only the in-page bits needs 30 ns. The reader remembers the open page and uses a short wait for in-page beats and a long wait for everything else. This covers the first beat after standby, a change of width mode, and a burst that steps into the next page.

In byte mode the top data pin is driven by the reader and carries the least-significant byte address bit. The result holds the returned byte on its low eight bits. After each burst the reader turns output-enable off and keeps the width line unchanged for a turnaround gap before accepting more work. If no request is waiting when the gap ends, it drops chip-enable and the memory enters standby.

Top module: `page_rom_reader`

## Requirements
- R1: `req_ready_o` is high only while no read is in progress (output-enable high), and a request is taken on a clock edge with `req_valid_i` and `req_ready_o` both high. `req_len_i` holds the beat count minus one. Beat k reads unit address `req_addr_i + k`.
- R2: When a request's first beat opens a page, the response for that beat appears `RAND_WAIT` cycles after the accepting edge.
- R3: A beat whose page tag equals that of the previous beat in the same burst appears `PAGE_WAIT` cycles after the previous beat. The page tag is unit address bits [21:3] in word mode and bits [22:4] in byte mode.
- R4: A beat whose page tag differs from the previous beat's, because the burst crossed a page boundary, appears `RAND_WAIT` cycles after the previous beat.
- R5: Byte mode (`req_byte_i`=1) works as follows:
  - `rom_byte_no` is 0 and `rom_d15_oe_o` is 1.
  - `rom_addr_o` is unit address bits [22:1] and `rom_d15_o` is unit address bit 0.
  - `rsp_data_o` is {8'h00, bus bits [7:0]}.
- R6: Word mode (`req_byte_i`=0) works as follows:
  - `rom_byte_no` is 1 and `rom_d15_oe_o` is 0.
  - `rom_addr_o` is unit address bits [21:0].
  - `rsp_data_o` is the whole 16-bit bus.
- R7: During a beat both chip-enable and output-enable are low. In the cycle after the last beat's response, output-enable is high, chip-enable is still low and `req_ready_o` is low. A request already waiting is accepted on the edge `TURN_WAIT`+1 cycles after the last beat's response edge.
- R8: `rom_byte_no` changes only when output-enable has been high for at least `TURN_WAIT` cycles.
- R9: If no request is taken in the cycle when the turnaround gap ends, chip-enable goes high (standby). The next request then uses the `RAND_WAIT` wait, even if it reads the page that was last open.
- R10: A request taken straight after the turnaround gap, in the same width mode and with the same page tag as the previous burst's last beat, delivers its first beat `PAGE_WAIT` cycles after the accepting edge.
- R11: After reset, chip-enable and output-enable are high, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R12: `rsp_last_o` is high with the final beat of each burst and low with every other beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | ADDR_W+1 | Start unit address (word index, or byte index in byte mode) |
| req_len_i | input | LEN_W | Beats minus one |
| req_byte_i | input | 1 | 1 = byte mode, 0 = word mode |
| rsp_valid_o | output | 1 | Response beat valid, one cycle |
| rsp_data_o | output | 16 | Response data |
| rsp_last_o | output | 1 | Final beat of the burst |
| rom_ce_no | output | 1 | Memory chip-enable, active low |
| rom_oe_no | output | 1 | Memory output-enable, active low |
| rom_byte_no | output | 1 | Width select, low = byte mode |
| rom_addr_o | output | ADDR_W | Memory address lines |
| rom_d15_o | output | 1 | Value for the top data pin when used as low address bit |
| rom_d15_oe_o | output | 1 | Drive enable for the top data pin |
| rom_data_i | input | 16 | Memory data bus |

## Verification
The bench's memory model drives unknown data until the right latency has passed since the last bus change. It uses 90 ns after chip-enable falls, after a width change or after a page change, and 30 ns otherwise. A reader that samples a cycle early therefore returns X, and one that waits a cycle too long misses the beat time the bench expects. The bench targets these cases:
- Bursts that cross a page boundary in both modes. A reader that kept the short wait after the crossing would read unknown data.
- Back-to-back requests into the still-open page. A reader that always used the long wait would deliver the first beat late.
- A width change straight after the gap. A reader that skipped the gap would change the width line too early.
- An idle pause before a same-page request. A reader that forgot standby had closed the page would use the short wait and sample X.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_HOLD,
    ST_OPEN
  } rd_state_e;
endpackage

// File: rtl/rom_rd_wait_ctr.sv
module rom_rd_wait_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/rom_rd_addr_gen.sv
module rom_rd_addr_gen #(
  parameter int ADDR_W = 22,
  parameter int PAGE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              track_i,
  input  logic              drop_i,
  input  logic [ADDR_W:0]   addr_i,
  input  logic              byte_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              lsb_o,
  output logic              byte_o,
  output logic              req_hit_o,
  output logic              next_hit_o
);
  localparam int TAG_W = ADDR_W - PAGE_W;

  logic [ADDR_W:0]  unit_q;
  logic             byte_q;
  logic [TAG_W-1:0] ptag_q;
  logic             pmode_q, pv_q;
  logic [TAG_W-1:0] cur_tag, nxt_tag, req_tag;
  logic [ADDR_W:0]  unit_nxt;

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W:0] u, logic b);
    return b ? u[ADDR_W:PAGE_W+1] : u[ADDR_W-1:PAGE_W];
  endfunction

  assign unit_nxt = unit_q + 1'b1;
  assign cur_tag  = tag_of(unit_q, byte_q);
  assign nxt_tag  = tag_of(unit_nxt, byte_q);
  assign req_tag  = tag_of(addr_i, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q <= '0;
      byte_q <= 1'b0;
    end else if (load_i) begin
      unit_q <= addr_i;
      byte_q <= byte_i;
    end else if (adv_i) begin
      unit_q <= unit_nxt;
    end
  end

  // open page record, valid only while chip-enable stays low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q    <= 1'b0;
      ptag_q  <= '0;
      pmode_q <= 1'b0;
    end else if (drop_i) begin
      pv_q    <= 1'b0;
    end else if (track_i) begin
      pv_q    <= 1'b1;
      ptag_q  <= cur_tag;
      pmode_q <= byte_q;
    end
  end

  assign rom_addr_o = byte_q ? unit_q[ADDR_W:1] : unit_q[ADDR_W-1:0];
  assign lsb_o      = unit_q[0];
  assign byte_o     = byte_q;
  assign req_hit_o  = pv_q && (pmode_q == byte_i) && (ptag_q == req_tag);
  assign next_hit_o = (nxt_tag == cur_tag);

  AST_DROP_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> !req_hit_o); // R9
endmodule

// File: rtl/rom_rd_lane.sv
module rom_rd_lane #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              last_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);
  localparam int HALF_W = DATA_W / 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= capture_i;
      last_o  <= capture_i && last_i;
      if (capture_i)
        data_o <= byte_i ? {{HALF_W{1'b0}}, bus_i[HALF_W-1:0]} : bus_i;
    end
  end

  AST_LAST_IN_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R12
endmodule

// File: rtl/page_rom_reader.sv
module page_rom_reader
  import rom_rd_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int PAGE_W    = 3,
  parameter int LEN_W     = 4,
  parameter int RAND_WAIT = 18,
  parameter int PAGE_WAIT = 6,
  parameter int TURN_WAIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W:0]   req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_byte_i,
  output logic              rsp_valid_o,
  output logic [15:0]       rsp_data_o,
  output logic              rsp_last_o,
  output logic              rom_ce_no,
  output logic              rom_oe_no,
  output logic              rom_byte_no,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              rom_d15_o,
  output logic              rom_d15_oe_o,
  input  logic [15:0]       rom_data_i
);
  localparam int MAX_WAIT = (RAND_WAIT > TURN_WAIT) ? RAND_WAIT : TURN_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int GAP_W    = $clog2(TURN_WAIT + 1);
  localparam logic [CNT_W-1:0] RW1 = CNT_W'(RAND_WAIT - 1);
  localparam logic [CNT_W-1:0] PW1 = CNT_W'(PAGE_WAIT - 1);
  localparam logic [CNT_W-1:0] TW1 = CNT_W'(TURN_WAIT - 1);

  rd_state_e        state_q, state_d;
  logic [LEN_W-1:0] beats_q;
  logic             accept, ctr_load, ctr_done;
  logic [CNT_W-1:0] ctr_val;
  logic             capture, adv, load, track, drop;
  logic             req_hit, next_hit, byte_sel, lsb;

  assign req_ready_o = (state_q == ST_IDLE) || (state_q == ST_OPEN);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d  = state_q;
    ctr_load = 1'b0;
    ctr_val  = '0;
    capture  = 1'b0;
    adv      = 1'b0;
    load     = 1'b0;
    track    = 1'b0;
    drop     = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_OPEN: begin
        if (accept) begin
          state_d  = ST_ACCESS;
          load     = 1'b1;
          ctr_load = 1'b1;
          ctr_val  = req_hit ? PW1 : RW1;
        end else if (state_q == ST_OPEN) begin
          state_d = ST_IDLE;
          drop    = 1'b1;
        end
      end
      ST_ACCESS: begin
        track = 1'b1;
        if (ctr_done) begin
          capture  = 1'b1;
          ctr_load = 1'b1;
          if (beats_q == '0) begin
            state_d = ST_HOLD;
            ctr_val = TW1;
          end else begin
            adv     = 1'b1;
            ctr_val = next_hit ? PW1 : RW1;
          end
        end
      end
      ST_HOLD: if (ctr_done) state_d = ST_OPEN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beats_q <= '0;
    end else begin
      state_q <= state_d;
      if (load)     beats_q <= req_len_i;
      else if (adv) beats_q <= beats_q - 1'b1;
    end
  end

  rom_rd_wait_ctr #(.CNT_W(CNT_W)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctr_load),
    .val_i  (ctr_val),
    .done_o (ctr_done)
  );

  rom_rd_addr_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .adv_i      (adv),
    .track_i    (track),
    .drop_i     (drop),
    .addr_i     (req_addr_i),
    .byte_i     (req_byte_i),
    .rom_addr_o (rom_addr_o),
    .lsb_o      (lsb),
    .byte_o     (byte_sel),
    .req_hit_o  (req_hit),
    .next_hit_o (next_hit)
  );

  rom_rd_lane #(.DATA_W(16)) u_lane (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .last_i    (beats_q == '0),
    .byte_i    (byte_sel),
    .bus_i     (rom_data_i),
    .valid_o   (rsp_valid_o),
    .data_o    (rsp_data_o),
    .last_o    (rsp_last_o)
  );

  assign rom_ce_no    = (state_q == ST_IDLE);
  assign rom_oe_no    = (state_q != ST_ACCESS);
  assign rom_byte_no  = ~byte_sel;
  assign rom_d15_o    = lsb;
  assign rom_d15_oe_o = byte_sel;

  // ---- assertion support ----
  logic [GAP_W-1:0] gap_q;
  logic [CNT_W-1:0] age_q;
  logic             hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= GAP_W'(TURN_WAIT);
      age_q <= '0;
      hit_q <= 1'b0;
    end else begin
      if (!rom_oe_no)                      gap_q <= '0;
      else if (gap_q != GAP_W'(TURN_WAIT)) gap_q <= gap_q + 1'b1;
      if (load || adv)                     age_q <= '0;
      else if (age_q != CNT_W'(MAX_WAIT))  age_q <= age_q + 1'b1;
      if (load)     hit_q <= req_hit;
      else if (adv) hit_q <= next_hit;
    end
  end

  AST_READY_WHEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> rom_oe_no); // R1
  AST_READ_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_oe_no |-> !rom_ce_no); // R7
  AST_TURN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_byte_no != $past(rom_byte_no)) |-> ($past(gap_q) == GAP_W'(TURN_WAIT))); // R8
  AST_PAGE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |-> (age_q >= PW1)); // R3
  AST_MISS_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture && !hit_q) |-> (age_q >= RW1)); // R4
endmodule

// File: tb/page_rom_reader_bench.sv
`timescale 1ns/1ps
module page_rom_reader_bench;
  localparam int RW = 18;
  localparam int PW = 6;
  localparam int TW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [22:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic        req_byte = 1'b0;
  logic        rsp_valid, rsp_last;
  logic [15:0] rsp_data;
  logic        ce_n, oe_n, byte_n, d15, d15_oe;
  logic [21:0] rom_addr;
  logic [15:0] mdl;
  logic [15:0] bus;

  always #2.5 clk = ~clk;

  page_rom_reader u_page_rom_reader (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_byte_i(req_byte),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_last_o(rsp_last),
    .rom_ce_no(ce_n), .rom_oe_no(oe_n), .rom_byte_no(byte_n),
    .rom_addr_o(rom_addr), .rom_d15_o(d15), .rom_d15_oe_o(d15_oe),
    .rom_data_i(bus)
  );

  assign bus = {d15_oe ? d15 : mdl[15], mdl[14:0]};

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] mem_word(logic [21:0] a);
    logic [15:0] m;
    m = 16'(a[15:0] * 16'h9e37);
    return m ^ {a[21:16], a[21:12]};
  endfunction

  function automatic logic [18:0] tag_of(logic [22:0] u, bit bm);
    return bm ? u[22:4] : u[21:3];
  endfunction

  function automatic logic [15:0] exp_data(logic [22:0] u, bit bm);
    logic [15:0] w;
    w = mem_word(bm ? u[22:1] : u[21:0]);
    return bm ? {8'h00, u[0] ? w[15:8] : w[7:0]} : w;
  endfunction

  // behavioural memory: unknown data until the access latency has run out
  int          gen = 0;
  logic        s_ce = 1'b1, s_oe = 1'b1, s_byte = 1'b1, s_lsb = 1'b0;
  logic [21:0] s_addr = '0;
  initial mdl = 'x;

  task automatic release_data(int g, realtime d);
    logic [15:0] w;
    #d;
    if (g == gen) begin
      w = mem_word(rom_addr);
      mdl = byte_n ? w : {8'bx, d15 ? w[15:8] : w[7:0]};
    end
  endtask

  always @(posedge clk) begin
    realtime lat;
    #0.1;
    if ({ce_n, oe_n, byte_n, rom_addr, d15} !== {s_ce, s_oe, s_byte, s_addr, s_lsb}) begin
      gen++;
      mdl = 'x;
      if (!ce_n && !oe_n) begin
        lat = (s_ce || (s_byte != byte_n) || (s_addr[21:3] != rom_addr[21:3])) ? 89.4 : 29.4;
        fork release_data(gen, lat); join_none
      end
      {s_ce, s_oe, s_byte, s_addr, s_lsb} = {ce_n, oe_n, byte_n, rom_addr, d15};
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bench view of the open page
  bit          pv = 0, pmode = 0;
  logic [18:0] ptag = '0;
  int          last_cyc = 0;

  task automatic do_req(logic [22:0] a, logic [3:0] len, bit bm, bit b2b);
    int wd, acc, w, exp_cyc;
    logic [18:0] prev, t;
    logic [22:0] u;
    bit old_byte_n;
    string rq;
    old_byte_n = byte_n;
    req_addr = a; req_len = len; req_byte = bm; req_valid = 1'b1;
    wd = 0;
    while (!req_ready && wd < 100) begin
      chk(byte_n == old_byte_n, "R8", "width line moved during gap", byte_n, old_byte_n);
      @(negedge clk); wd++;
    end
    acc = cyc + 1;
    if (b2b) chk(acc == last_cyc + TW + 1, "R7", "accept edge after gap", acc, last_cyc + TW + 1);
    t = tag_of(a, bm);
    w = (pv && pmode == bm && ptag == t) ? PW : RW;
    rq = (w == PW) ? "R10" : "R2";
    exp_cyc = acc + w;
    prev = t;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k <= int'(len); k++) begin
      u = a + 23'(k);
      if (k > 0) begin
        t = tag_of(u, bm);
        rq = (t == prev) ? "R3" : "R4";
        exp_cyc += (t == prev) ? PW : RW;
        prev = t;
      end
      wd = 0;
      while (!rsp_valid && wd < 400) begin
        chk(!req_ready, "R1", "ready during read", req_ready, 0);
        if (!oe_n) chk(!ce_n, "R7", "ce low while reading", ce_n, 0);
        @(negedge clk); wd++;
      end
      chk(cyc == exp_cyc, rq, "beat cycle", cyc, exp_cyc);
      chk(rsp_data === exp_data(u, bm), bm ? "R5" : "R6", "beat data", rsp_data, exp_data(u, bm));
      chk(rsp_last == (k == int'(len)), "R12", "last flag", rsp_last, k == int'(len));
      chk({byte_n, d15_oe} == {~bm, bm}, bm ? "R5" : "R6", "width pins", {byte_n, d15_oe}, {~bm, bm});
      last_cyc = cyc;
      @(negedge clk);
    end
    chk({oe_n, ce_n, req_ready} == 3'b100, "R7", "hold after burst", {oe_n, ce_n, req_ready}, 3'b100);
    pv = 1; ptag = prev; pmode = bm;
  endtask

  task automatic idle_gap(int extra);
    repeat (TW + extra) @(negedge clk);
    chk(ce_n && req_ready, "R9", "standby after gap", {ce_n, req_ready}, 2'b11);
    pv = 0;
  endtask

  initial begin
    logic [22:0] a, nxt;
    bit bm, b2b, lbm;
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ce_n, oe_n, req_ready, rsp_valid} == 4'b1110, "R11", "reset state",
        {ce_n, oe_n, req_ready, rsp_valid}, 4'b1110);
    do_req(23'h000100, 4'd7, 0, 0);       // whole page, word mode
    do_req(23'h000105, 4'd5, 0, 1);       // crosses page
    do_req(23'h00010a, 4'd0, 0, 1);       // open page hit
    do_req(23'h000214, 4'd3, 1, 1);       // width change after gap
    do_req(23'h00021c, 4'd7, 1, 1);       // byte burst crossing page
    idle_gap(2);
    do_req(23'h000222, 4'd1, 1, 0);       // same page after standby
    lbm = 1; nxt = 23'h000224;
    for (int i = 0; i < 60; i++) begin
      bm = 1'($urandom);
      b2b = 1'($urandom);
      case ($urandom % 3)
        0: a = 23'($urandom);
        1: begin a = nxt; bm = lbm; end
        default: begin a = 23'($urandom); a[3:0] = bm ? 4'hc : {a[3], 3'h5}; end
      endcase
      if (!b2b) idle_gap(1 + int'($urandom % 4));
      do_req(a, 4'($urandom), bm, b2b);
      nxt = a + 23'(req_len) + 23'd1; lbm = bm;
    end
    idle_gap(1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule